// File: doc/BRIEF.md
# Bus-Lost Safe-Position Supervisor

This block watches the health of the serial control bus of a motor-driving slave node. It counts frame periods that pass without a valid frame. When too many pass in a row, it declares the link lost and takes a fallback action. If the stored 11-bit safe position holds a real target, the block loads that value into the target-position output, pulses a move start and waits for the motion engine to report completion before it requests sleep. If the safe position holds the sentinel code 0x400, the block requests sleep at once. A fault on the hardwired address pins has the same effect as a lost link.

After power-up the node stays in shutdown with the motor unpowered. It leaves shutdown only when the first valid full-status read arrives. Until then, neither silence on the bus nor an address fault causes a safe-position move. Once a loss has been declared, the lost flag and the sleep request hold until the next reset.

Top module: `link_loss_guard`

## Requirements
- R1: After reset the block is in shutdown: `motor_enable`, `sleep_req`, `link_lost` and `move_start` are all 0, and `target_pos` is 0.
- R2: In shutdown, `period_tick`, the absence of frames and `addr_fault` have no effect: `link_lost` stays 0 and `motor_enable` stays 0. A `status_read` strobe moves the block to run, and `motor_enable` reads 1 in the following cycle.
- R3: In run, a `frame_ok` strobe clears the count of consecutive silent periods. When `frame_ok` and `period_tick` arrive in the same cycle, the clear wins and the tick is not counted.
- R4: In run, the link is declared lost in the cycle that carries the LOSS_PERIODS-th consecutive `period_tick` with no `frame_ok` in between (default 25000). `link_lost` reads 1 from the next cycle; with one period fewer it stays 0.
- R5: In run, `addr_fault` high for one cycle declares the link lost in the same way as a timeout.
- R6: On a loss with `secure_pos` different from 0x400, `target_pos` is loaded with `secure_pos`, and `move_start` is 1 for exactly one cycle, the same cycle in which `link_lost` first reads 1.
- R7: During the safe move, `motor_enable` stays 1 and `sleep_req` stays 0 until `move_done` is sampled high. From the next cycle, `sleep_req` is 1 and `motor_enable` is 0.
- R8: On a loss with `secure_pos` equal to 0x400, no `move_start` is issued and `target_pos` is left unchanged. `sleep_req` reads 1 and `motor_enable` reads 0 from the cycle in which `link_lost` first reads 1.
- R9: Once set, `link_lost` and `sleep_req` stay 1 until reset, whatever arrives on `frame_ok`, `status_read` or `period_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ok | input | 1 | One-cycle strobe for a valid received frame |
| status_read | input | 1 | One-cycle strobe for a valid full-status read |
| period_tick | input | 1 | One-cycle strobe per elapsed frame period |
| addr_fault | input | 1 | Hardwired address is floating or invalid |
| secure_pos | input | POS_W | Stored safe position; 0x400 means no move |
| move_done | input | 1 | Motion engine has finished the commanded move |
| target_pos | output | POS_W | Absolute target handed to the motion engine |
| move_start | output | 1 | One-cycle pulse that starts the safe move |
| sleep_req | output | 1 | Request to enter sleep |
| motor_enable | output | 1 | Motor may be powered |
| link_lost | output | 1 | Sticky flag: the link was declared lost |

## Verification
The bench targets the exact timeout edge. With one period short of the limit the flag must stay low, and a design with an off-by-one counter would declare the loss a period early or late. It drives a frame and a tick in the same cycle; a design that let the tick win would time out too soon. It keeps ticks and address faults active during shutdown, so a supervisor that armed itself before the first status read would start an unwanted move. It also draws safe positions at random, including the 0x400 sentinel, and checks that the move starts exactly once, that sleep waits for move completion, and that the lost flag does not clear when traffic returns, which a design with a level-sensitive flag would do.

// File: rtl/link_loss_guard.sv
module link_loss_guard #(
  parameter int LOSS_PERIODS = 25000,
  parameter int POS_W = 11,
  parameter logic [POS_W-1:0] NO_MOVE_POS = POS_W'(1) << (POS_W-1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ok,
  input  logic             status_read,
  input  logic             period_tick,
  input  logic             addr_fault,
  input  logic [POS_W-1:0] secure_pos,
  input  logic             move_done,
  output logic [POS_W-1:0] target_pos,
  output logic             move_start,
  output logic             sleep_req,
  output logic             motor_enable,
  output logic             link_lost
);
  localparam int CNT_W = $clog2(LOSS_PERIODS + 1);

  typedef enum logic [1:0] {ST_SHUTDOWN, ST_RUN, ST_SECURE_MOVE, ST_SLEEP} state_t;

  state_t           state;
  logic [CNT_W-1:0] gap_cnt;

  wire last_period = period_tick && !frame_ok && (gap_cnt == CNT_W'(LOSS_PERIODS - 1));
  wire lost_now    = (state == ST_RUN) && (addr_fault || last_period);
  wire park_direct = (secure_pos == NO_MOVE_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_SHUTDOWN;
      gap_cnt    <= '0;
      target_pos <= '0;
      move_start <= 1'b0;
      link_lost  <= 1'b0;
    end else begin
      move_start <= 1'b0;
      case (state)
        ST_SHUTDOWN: begin
          gap_cnt <= '0;
          if (status_read) state <= ST_RUN;
        end
        ST_RUN: begin
          if (lost_now) begin
            link_lost <= 1'b1;
            gap_cnt   <= '0;
            if (park_direct) begin
              state <= ST_SLEEP;
            end else begin
              state      <= ST_SECURE_MOVE;
              target_pos <= secure_pos;
              move_start <= 1'b1;
            end
          end else if (frame_ok) begin
            gap_cnt <= '0;
          end else if (period_tick) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SECURE_MOVE: if (move_done) state <= ST_SLEEP;
        default: state <= ST_SLEEP;
      endcase
    end
  end

  assign motor_enable = (state == ST_RUN) || (state == ST_SECURE_MOVE);
  assign sleep_req    = (state == ST_SLEEP);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    move_start |=> !move_start); // R6
  AST_START_WITH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    move_start |-> (link_lost && target_pos != NO_MOVE_POS && motor_enable)); // R6
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |=> link_lost); // R9
  AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> sleep_req); // R9
  AST_SLEEP_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (link_lost && !motor_enable)); // R7
  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!motor_enable && !sleep_req) |-> (!link_lost && !move_start)); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_cnt) < LOSS_PERIODS); // R4
endmodule

// File: tb/link_loss_guard_tb.sv
module link_loss_guard_tb;
  localparam int L = 12;
  localparam logic [10:0] PARK = 11'h400;

  logic clk = 1'b0;
  logic rst_n, frame_ok, status_read, period_tick, addr_fault, move_done;
  logic [10:0] secure_pos, target_pos;
  logic move_start, sleep_req, motor_enable, link_lost;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  link_loss_guard #(.LOSS_PERIODS(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .status_read(status_read),
    .period_tick(period_tick), .addr_fault(addr_fault), .secure_pos(secure_pos),
    .move_done(move_done), .target_pos(target_pos), .move_start(move_start),
    .sleep_req(sleep_req), .motor_enable(motor_enable), .link_lost(link_lost));

  function automatic bit exp_trigger(int cnt, bit tick, bit frame, bit fault);
    return fault || (tick && !frame && cnt == L - 1);
  endfunction

  function automatic int exp_count(int cnt, bit tick, bit frame);
    if (frame) return 0;
    return tick ? cnt + 1 : cnt;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    frame_ok = 0; status_read = 0; period_tick = 0; addr_fault = 0; move_done = 0;
  endtask

  task automatic do_reset_to_run(logic [10:0] pos);
    idle_inputs();
    secure_pos = pos;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
    chk("R1 motor", motor_enable, 0);
    chk("R1 sleep", sleep_req, 0);
    chk("R1 lost", link_lost, 0);
    chk("R1 start", move_start, 0);
    chk("R1 target", target_pos, 0);
    for (int i = 0; i < 2 * L; i++) begin
      period_tick = 1;
      addr_fault = $urandom % 2;
      step();
      chk("R2 lost in shutdown", link_lost, 0);
      chk("R2 motor in shutdown", motor_enable, 0);
    end
    idle_inputs();
    status_read = 1;
    step();
    status_read = 0;
    chk("R2 run after status", motor_enable, 1);
  endtask

  task automatic fallback_checks(logic [10:0] pos);
    if (pos != PARK) begin
      chk("R6 start pulse", move_start, 1);
      chk("R6 target", target_pos, pos);
      chk("R6 lost with start", link_lost, 1);
      step();
      chk("R6 start single", move_start, 0);
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R7 no sleep yet", sleep_req, 0);
        chk("R7 motor during move", motor_enable, 1);
      end
      move_done = 1;
      step();
      move_done = 0;
      chk("R7 sleep after done", sleep_req, 1);
      chk("R7 motor off", motor_enable, 0);
    end else begin
      chk("R8 no start", move_start, 0);
      chk("R8 sleep direct", sleep_req, 1);
      chk("R8 motor off", motor_enable, 0);
      chk("R8 target unchanged", target_pos, 0);
      step();
      chk("R8 still no start", move_start, 0);
    end
    for (int k = 0; k < 3; k++) begin
      frame_ok = 1; status_read = 1; period_tick = 1;
      step();
      chk("R9 lost sticky", link_lost, 1);
      chk("R9 sleep sticky", sleep_req, 1);
      chk("R9 motor off", motor_enable, 0);
    end
    idle_inputs();
  endtask

  task automatic random_episode(logic [10:0] pos, bit fault_mode, int fault_at);
    int cnt = 0;
    int cyc = 0;
    bit trig = 0;
    do_reset_to_run(pos);
    while (!trig) begin
      period_tick = $urandom % 2;
      frame_ok = ($urandom % 6) == 0;
      addr_fault = fault_mode && (cyc == fault_at);
      trig = exp_trigger(cnt, period_tick, frame_ok, addr_fault);
      cnt = exp_count(cnt, period_tick, frame_ok);
      step();
      if (trig) chk(fault_mode ? "R5 lost flag" : "R4 lost flag", link_lost, 1);
      else chk("R3 not lost yet", link_lost, 0);
      idle_inputs();
      cyc++;
    end
    fallback_checks(pos);
  endtask

  task automatic directed_tie();
    do_reset_to_run(11'h123);
    for (int i = 0; i < L - 1; i++) begin
      period_tick = 1;
      step();
    end
    chk("R4 one short", link_lost, 0);
    period_tick = 1; frame_ok = 1;
    step();
    frame_ok = 0;
    chk("R3 tie frame wins", link_lost, 0);
    for (int i = 0; i < L - 1; i++) begin
      step();
      chk("R3 count restarted", link_lost, 0);
    end
    step();
    period_tick = 0;
    chk("R4 exact limit", link_lost, 1);
    fallback_checks(11'h123);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    idle_inputs();
    rst_n = 0;
    secure_pos = 0;
    directed_tie();
    random_episode(PARK, 0, 0);
    random_episode(PARK, 1, 3);
    random_episode(11'h7FF, 1, 0);
    for (int e = 0; e < 30; e++) begin
      logic [10:0] p;
      p = ($urandom % 4 == 0) ? PARK : 11'($urandom);
      random_episode(p, ($urandom % 3) == 0, $urandom % 20);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule